// File: doc/BRIEF.md
# 64B/66B Sync Header Block Aligner

This block takes raw line bits from a deserializer, 66 bits per accepted word, and finds where the 66-bit coded blocks begin. It tries one bit offset at a time and watches the 2-bit header that opens each candidate block. After a long run of legal headers at one offset, it declares block lock and starts passing each block's 64 payload bits downstream.

While block lock holds, the first header bit of every block is shifted into a 32-bit sync message register. A five-bit pilot sits at the tail of every 32-block message. Finding that pilot at a steady position gives multiblock lock. From then on, the block marks the first block of each multiblock. It also counts multiblocks and marks the first block of each extended multiblock, whose length is a parameter.

Both sides use valid/ready handshakes. A word is accepted on a cycle where `in_valid` and `in_ready` are both high. Each accepted word moves through one output register. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat and its flags hold still and no new word is accepted.

Top module: `shdr_aligner`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `block_lock`, `mb_lock`, every counter and the bit offset to zero.
- R2: Bit 0 of `in_word` is the earliest bit on the line. A header is the first two bits of a block, and it is legal only when those two bits differ (01 or 10). While unlocked, an illegal header at the current offset moves the offset on by one bit, wrapping from 65 to 0. The 64th consecutive legal header at one offset sets `block_lock`.
- R3: While locked, blocks are counted in consecutive 64-block windows, the first window starting right after lock. The 16th illegal header inside one window clears `block_lock` and slips the offset by one bit. Fifteen or fewer illegal headers in a window leave lock in place.
- R4: Each word accepted while `block_lock` is already high produces exactly one output beat. The beat's `out_data` holds block bits 2 to 65, with block bit 2 on `out_data[0]`. Words accepted while unlocked produce no beat.
- R5: Each block accepted while locked adds its first header bit to the sync message (header 10 adds 1, header 01 adds 0). The oldest bit of the message is held at the top of the register.
- R6: The pilot is 0,0,0,0,1 in arrival order, ending a message. `mb_lock` is set when the pilot is found at the same 32-block position in four consecutive messages. `mb_lock` is cleared after four consecutive messages miss it.
- R7: `out_mb_start` is high only on the beat of the block that follows a pilot-ending block, and only while multiblock lock was held when that block was accepted.
- R8: `out_emb_start` marks the first multiblock after lock is gained, and then every EMB_LEN-th multiblock (default 4). It is only ever high together with `out_mb_start`.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the flags do not change.
- R10: Losing block lock clears `mb_lock` on the same clock edge, so `mb_lock` is never high while `block_lock` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Line word offered |
| in_ready | output | 1 | Line word can be taken |
| in_word | input | 66 | Line bits, bit 0 earliest |
| out_valid | output | 1 | Payload beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 64 | Block payload |
| out_mb_start | output | 1 | Beat opens a multiblock |
| out_emb_start | output | 1 | Beat opens an extended multiblock |
| block_lock | output | 1 | Block boundary found |
| mb_lock | output | 1 | Multiblock boundary found |

## Verification
The bench starts the stream at a bit offset of 17 from the word edge. A design that slipped wrongly or picked the wrong window would then send out shifted payloads. Bursts of 15 and of 40 illegal headers probe the window limit: an off-by-one counter either drops lock too early or keeps it too long. Runs of three and then four broken pilots separate a miss counter that is correct from one that is off by one. A tracker that fails to reset its extended-multiblock count would put `out_emb_start` at the wrong spacing. Heavy random back-pressure catches beats that are lost, duplicated or changed while stalled.

// File: rtl/shdr_pkg.sv
package shdr_pkg;

  localparam int HDR_W = 2;

  typedef struct packed {
    logic mb;
    logic emb;
  } shdr_mark_t;

  function automatic logic hdr_ok(input logic [HDR_W-1:0] h);
    return h[0] ^ h[1];
  endfunction

endpackage

// File: rtl/shdr_window.sv
module shdr_window #(
  parameter int BLK_W = 66,
  localparam int OFF_W = $clog2(BLK_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [BLK_W-1:0] word,
  input  logic [OFF_W-1:0] off,
  output logic [BLK_W-1:0] blk
);

  logic [BLK_W-1:0]   prev_q;
  logic [2*BLK_W-1:0] cat;

  assign cat = {word, prev_q};
  assign blk = cat[off +: BLK_W];

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= '0;
    else if (take) prev_q <= word;
  end

endmodule

// File: rtl/shdr_lock.sv
module shdr_lock #(
  parameter int BLK_W  = 66,
  parameter int GOOD_N = 64,
  parameter int BAD_N  = 16,
  parameter int WIN_N  = 64,
  localparam int OFF_W = $clog2(BLK_W),
  localparam int GC_W  = $clog2(GOOD_N),
  localparam int BC_W  = $clog2(BAD_N),
  localparam int WC_W  = $clog2(WIN_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [1:0]       hdr,
  output logic             locked,
  output logic             lose,
  output logic [OFF_W-1:0] off
);
  import shdr_pkg::*;

  logic             lock_q, lock_n;
  logic [OFF_W-1:0] off_q, off_n, off_slip;
  logic [GC_W-1:0]  good_q, good_n;
  logic [BC_W-1:0]  bad_q, bad_n;
  logic [WC_W-1:0]  win_q, win_n;
  logic             legal;

  assign legal    = hdr_ok(hdr);
  assign off_slip = (off_q == OFF_W'(BLK_W-1)) ? '0 : off_q + OFF_W'(1);

  always_comb begin
    lock_n = lock_q;
    off_n  = off_q;
    good_n = good_q;
    bad_n  = bad_q;
    win_n  = win_q;
    lose   = 1'b0;
    if (take) begin
      if (!lock_q) begin
        if (legal) begin
          if (good_q == GC_W'(GOOD_N-1)) begin
            lock_n = 1'b1;
            good_n = '0;
            bad_n  = '0;
            win_n  = '0;
          end else begin
            good_n = good_q + GC_W'(1);
          end
        end else begin
          good_n = '0;
          off_n  = off_slip;
        end
      end else if (!legal && bad_q == BC_W'(BAD_N-1)) begin
        lose   = 1'b1;
        lock_n = 1'b0;
        off_n  = off_slip;
        good_n = '0;
        bad_n  = '0;
        win_n  = '0;
      end else begin
        if (!legal) bad_n = bad_q + BC_W'(1);
        if (win_q == WC_W'(WIN_N-1)) begin
          win_n = '0;
          bad_n = '0;
        end else begin
          win_n = win_q + WC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      off_q  <= '0;
      good_q <= '0;
      bad_q  <= '0;
      win_q  <= '0;
    end else begin
      lock_q <= lock_n;
      off_q  <= off_n;
      good_q <= good_n;
      bad_q  <= bad_n;
      win_q  <= win_n;
    end
  end

  assign locked = lock_q;
  assign off    = off_q;

endmodule

// File: rtl/shdr_mbtrack.sv
module shdr_mbtrack #(
  parameter int MSG_LEN   = 32,
  parameter int PILOT_LEN = 5,
  parameter logic [PILOT_LEN-1:0] PILOT = 5'b00001,
  parameter int CONFIRM_N = 4,
  parameter int MISS_N    = 4,
  parameter int EMB_LEN   = 4,
  localparam int PW = $clog2(MSG_LEN),
  localparam int HW = $clog2(CONFIRM_N + 1),
  localparam int MW = $clog2(MISS_N + 1),
  localparam int EW = (EMB_LEN > 1) ? $clog2(EMB_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic active,
  input  logic flush,
  input  logic msg_bit,
  output logic mb_locked,
  output logic mb_first,
  output logic emb_first
);

  logic [MSG_LEN-1:0] msg_q, msg_n;
  logic               cand_q, cand_n;
  logic [HW-1:0]      hits_q, hits_n;
  logic [PW-1:0]      pos_q, pos_n;
  logic               mlock_q, mlock_n;
  logic [MW-1:0]      miss_q, miss_n;
  logic               match, last, gain, emb_zero;

  assign match = {msg_q[PILOT_LEN-2:0], msg_bit} == PILOT;
  assign last  = pos_q == PW'(MSG_LEN-1);

  always_comb begin
    msg_n   = msg_q;
    cand_n  = cand_q;
    hits_n  = hits_q;
    pos_n   = pos_q;
    mlock_n = mlock_q;
    miss_n  = miss_q;
    gain    = 1'b0;
    if (take && flush) begin
      msg_n   = '0;
      cand_n  = 1'b0;
      hits_n  = '0;
      pos_n   = '0;
      mlock_n = 1'b0;
      miss_n  = '0;
    end else if (take && active) begin
      msg_n = {msg_q[MSG_LEN-2:0], msg_bit};
      if (!mlock_q) begin
        if (!cand_q) begin
          if (match) begin
            cand_n = 1'b1;
            pos_n  = '0;
            hits_n = HW'(1);
          end
        end else if (last) begin
          pos_n = '0;
          if (match) begin
            if (hits_q == HW'(CONFIRM_N-1)) begin
              mlock_n = 1'b1;
              gain    = 1'b1;
              hits_n  = '0;
              miss_n  = '0;
            end else begin
              hits_n = hits_q + HW'(1);
            end
          end else begin
            cand_n = 1'b0;
            hits_n = '0;
          end
        end else begin
          pos_n = pos_q + PW'(1);
        end
      end else if (last) begin
        pos_n = '0;
        if (match) begin
          miss_n = '0;
        end else if (miss_q == MW'(MISS_N-1)) begin
          mlock_n = 1'b0;
          cand_n  = 1'b0;
          hits_n  = '0;
          miss_n  = '0;
        end else begin
          miss_n = miss_q + MW'(1);
        end
      end else begin
        pos_n = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_q   <= '0;
      cand_q  <= 1'b0;
      hits_q  <= '0;
      pos_q   <= '0;
      mlock_q <= 1'b0;
      miss_q  <= '0;
    end else begin
      msg_q   <= msg_n;
      cand_q  <= cand_n;
      hits_q  <= hits_n;
      pos_q   <= pos_n;
      mlock_q <= mlock_n;
      miss_q  <= miss_n;
    end
  end

  generate
    if (EMB_LEN == 1) begin : g_emb_one
      assign emb_zero = 1'b1;
    end else begin : g_emb_cnt
      logic [EW-1:0] emb_q;
      always_ff @(posedge clk) begin
        if (rst || (take && (flush || gain))) begin
          emb_q <= '0;
        end else if (take && mlock_q && pos_q == '0) begin
          emb_q <= (emb_q == EW'(EMB_LEN-1)) ? '0 : emb_q + EW'(1);
        end
      end
      assign emb_zero = emb_q == '0;
    end
  endgenerate

  assign mb_locked = mlock_q;
  assign mb_first  = mlock_q && pos_q == '0;
  assign emb_first = mb_first && emb_zero;

endmodule

// File: rtl/shdr_aligner.sv
module shdr_aligner #(
  parameter int BLK_W     = 66,
  parameter int GOOD_N    = 64,
  parameter int BAD_N     = 16,
  parameter int WIN_N     = 64,
  parameter int MSG_LEN   = 32,
  parameter int PILOT_LEN = 5,
  parameter logic [PILOT_LEN-1:0] PILOT = 5'b00001,
  parameter int CONFIRM_N = 4,
  parameter int MISS_N    = 4,
  parameter int EMB_LEN   = 4,
  localparam int PAY_W = BLK_W - shdr_pkg::HDR_W,
  localparam int OFF_W = $clog2(BLK_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data,
  output logic             out_mb_start,
  output logic             out_emb_start,
  output logic             block_lock,
  output logic             mb_lock
);
  import shdr_pkg::*;

  logic             take;
  logic [BLK_W-1:0] blk;
  logic [OFF_W-1:0] off;
  logic             locked, lose;
  logic             mb_first, emb_first, mb_locked;
  logic             ovalid_q;
  logic [PAY_W-1:0] odata_q;
  shdr_mark_t       mark_q;

  assign in_ready = !ovalid_q || out_ready;
  assign take     = in_valid && in_ready;

  shdr_window #(.BLK_W(BLK_W)) u_window (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .word (in_word),
    .off  (off),
    .blk  (blk)
  );

  shdr_lock #(
    .BLK_W (BLK_W),
    .GOOD_N(GOOD_N),
    .BAD_N (BAD_N),
    .WIN_N (WIN_N)
  ) u_lock (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .hdr   (blk[HDR_W-1:0]),
    .locked(locked),
    .lose  (lose),
    .off   (off)
  );

  shdr_mbtrack #(
    .MSG_LEN  (MSG_LEN),
    .PILOT_LEN(PILOT_LEN),
    .PILOT    (PILOT),
    .CONFIRM_N(CONFIRM_N),
    .MISS_N   (MISS_N),
    .EMB_LEN  (EMB_LEN)
  ) u_mb (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .active   (locked),
    .flush    (lose),
    .msg_bit  (blk[0]),
    .mb_locked(mb_locked),
    .mb_first (mb_first),
    .emb_first(emb_first)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovalid_q <= 1'b0;
      odata_q  <= '0;
      mark_q   <= '0;
    end else if (take) begin
      ovalid_q   <= locked;
      odata_q    <= blk[BLK_W-1:HDR_W];
      mark_q.mb  <= locked && mb_first;
      mark_q.emb <= locked && emb_first;
    end else if (out_ready) begin
      ovalid_q <= 1'b0;
      mark_q   <= '0;
    end
  end

  assign out_valid     = ovalid_q;
  assign out_data      = odata_q;
  assign out_mb_start  = mark_q.mb;
  assign out_emb_start = mark_q.emb;
  assign block_lock    = locked;
  assign mb_lock       = mb_locked;

endmodule

// File: rtl/shdr_aligner_chk.sv
module shdr_aligner_chk #(
  parameter int PAY_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PAY_W-1:0] out_data,
  input logic             out_mb_start,
  input logic             out_emb_start,
  input logic             block_lock,
  input logic             mb_lock
);

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(out_mb_start) && $stable(out_emb_start)));

  // R9
  ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  // R7
  mb_flag_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_mb_start |-> out_valid);

  // R8
  emb_in_mb_chk: assert property (@(posedge clk) disable iff (rst)
    out_emb_start |-> out_mb_start);

  // R10
  mb_needs_blk_chk: assert property (@(posedge clk) disable iff (rst)
    mb_lock |-> block_lock);

  // R10
  blk_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(block_lock) |-> !mb_lock);

endmodule

bind shdr_aligner shdr_aligner_chk #(.PAY_W(PAY_W)) u_chk (.*);

// File: tb/shdr_aligner_test.sv
module shdr_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int EMB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [65:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_mb_start, out_emb_start, block_lock, mb_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  shdr_aligner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mb_start(out_mb_start),
    .out_emb_start(out_emb_start), .block_lock(block_lock), .mb_lock(mb_lock)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural reference state
  bit        rq[$];
  int        m_s, m_good, m_bad, m_win, m_hits, m_pos, m_miss, m_emb;
  bit        m_bl, m_mbl, m_cand, m_ov, m_mbs, m_embs;
  bit [31:0] m_msg;
  bit [63:0] m_data;

  int  mb_since = 0, seen_mb = 0, seen_emb = 0, spacing_ok = 0, stalls = 0;
  bit  hold = 0;
  logic [63:0] held_data;

  task automatic model_take(input logic [65:0] w);
    bit b[66];
    bit lp, mp, legal, match, drop;
    for (int i = 0; i < 66; i++) rq.push_back(w[i]);
    while (rq.size() > 132) for (int i = 0; i < 66; i++) void'(rq.pop_front());
    for (int i = 0; i < 66; i++) b[i] = rq[m_s + i];
    lp = m_bl; mp = m_mbl; legal = (b[0] != b[1]); drop = 0;
    m_ov = lp;
    if (lp) begin
      for (int i = 0; i < 64; i++) m_data[i] = b[i+2];
      m_mbs  = mp && (m_pos == 0);
      m_embs = m_mbs && (m_emb == 0);
    end
    if (!m_bl) begin
      if (legal) begin
        m_good++;
        if (m_good == 64) begin m_bl = 1; m_good = 0; m_bad = 0; m_win = 0; end
      end else begin
        m_good = 0; m_s = (m_s + 1) % 66;
      end
    end else begin
      m_win++;
      if (!legal) m_bad++;
      if (m_bad == 16) begin
        m_bl = 0; drop = 1; m_s = (m_s + 1) % 66; m_win = 0; m_bad = 0; m_good = 0;
      end else if (m_win == 64) begin
        m_win = 0; m_bad = 0;
      end
    end
    if (lp) begin
      m_msg = {m_msg[30:0], b[0]};
      match = (m_msg[4:0] == 5'b00001);
      if (!mp) begin
        if (!m_cand) begin
          if (match) begin m_cand = 1; m_pos = 0; m_hits = 1; end
        end else if (m_pos == 31) begin
          m_pos = 0;
          if (match) begin
            m_hits++;
            if (m_hits == 4) begin m_mbl = 1; m_emb = 0; m_miss = 0; end
          end else begin
            m_cand = 0; m_hits = 0;
          end
        end else m_pos++;
      end else begin
        if (m_pos == 0) m_emb = (m_emb + 1) % EMB;
        if (m_pos == 31) begin
          m_pos = 0;
          if (match) m_miss = 0;
          else begin
            m_miss++;
            if (m_miss == 4) begin m_mbl = 0; m_cand = 0; m_hits = 0; m_miss = 0; end
          end
        end else m_pos++;
      end
      if (drop) begin
        m_msg = 0; m_cand = 0; m_hits = 0; m_pos = 0; m_mbl = 0; m_miss = 0; m_emb = 0;
      end
    end
  endtask

  task automatic step(input bit v, input logic [65:0] w, input bit rdy, output bit took);
    bit fi, fo;
    @(negedge clk);
    in_valid = v; in_word = w; out_ready = rdy;
    #1;
    chk(in_ready == (!m_ov || rdy), "R9 in_ready", in_ready, !m_ov || rdy);
    chk(out_valid == m_ov, "R4 out_valid", out_valid, m_ov);
    if (hold) chk(out_data == held_data, "R9 data held in stall", out_data, held_data);
    if (m_ov) begin
      chk(out_data == m_data, "R4 payload", out_data, m_data);
      chk(out_mb_start == m_mbs, "R7 mb_start", out_mb_start, m_mbs);
      chk(out_emb_start == m_embs, "R8 emb_start", out_emb_start, m_embs);
    end
    fi = v && in_ready;
    fo = out_valid && rdy;
    hold = out_valid && !rdy;
    if (hold) begin held_data = out_data; stalls++; end
    if (fo && out_mb_start) begin
      seen_mb++;
      if (out_emb_start) begin
        seen_emb++;
        if (mb_since > 0) begin
          chk(mb_since == EMB, "R8 extended spacing", mb_since, EMB);
          spacing_ok++;
        end
        mb_since = 1;
      end else if (mb_since > 0) mb_since++;
    end
    @(posedge clk);
    #1;
    if (fo) m_ov = 0;
    if (fi) model_take(w);
    chk(block_lock == m_bl, "R2 R3 block_lock", block_lock, m_bl);
    chk(mb_lock == m_mbl, "R6 mb_lock", mb_lock, m_mbl);
    if (!mb_lock) mb_since = 0;
    took = fi;
  endtask

  // transmit side
  bit txq[$];

  task automatic push_msg(input bit broken, input int bad_first, input int bad_n);
    bit [31:0] mbits;
    bit h0;
    mbits = $urandom;
    for (int i = 27; i < 31; i++) mbits[i] = 1'b0;
    mbits[31] = !broken;
    for (int i = 0; i < 32; i++) begin
      if (i >= bad_first && i < bad_first + bad_n) begin
        h0 = $urandom % 2;
        txq.push_back(h0); txq.push_back(h0);
      end else begin
        txq.push_back(mbits[i]); txq.push_back(!mbits[i]);
      end
      for (int k = 0; k < 64; k++) txq.push_back($urandom % 2);
    end
  endtask

  task automatic send_all(input int idle_pct, input int stall_pct);
    logic [65:0] w;
    bit t, rdy;
    while (txq.size() >= 66) begin
      for (int i = 0; i < 66; i++) w[i] = txq.pop_front();
      t = 0;
      while (!t) begin
        rdy = ($urandom % 100) >= stall_pct;
        if (($urandom % 100) < idle_pct) step(0, '0, rdy, t);
        else step(1, w, rdy, t);
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 66; i++) rq.push_back(1'b0);
    repeat (3) @(negedge clk);
    #1;
    // R1 state held under reset
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(block_lock == 0, "R1 block_lock in reset", block_lock, 0);
    chk(mb_lock == 0, "R1 mb_lock in reset", mb_lock, 0);
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < 17; i++) txq.push_back($urandom % 2);

    repeat (24) push_msg(0, 0, 0);
    send_all(10, 0);
    chk(block_lock == 1, "R2 lock found at offset 17", block_lock, 1);
    chk(mb_lock == 1, "R5 R6 multiblock lock found", mb_lock, 1);
    chk(seen_mb > 0, "R7 multiblock starts seen", seen_mb, 1);
    chk(spacing_ok > 0, "R8 extended spacing observed", spacing_ok, 1);

    push_msg(0, 3, 15);
    push_msg(0, 0, 0);
    send_all(0, 0);
    chk(block_lock == 1, "R3 fifteen bad headers tolerated", block_lock, 1);

    repeat (3) push_msg(1, 0, 0);
    push_msg(0, 0, 0);
    send_all(0, 0);
    chk(mb_lock == 1, "R6 three missed pilots tolerated", mb_lock, 1);

    repeat (4) push_msg(1, 0, 0);
    push_msg(0, 0, 0);
    send_all(0, 0);
    chk(mb_lock == 0, "R6 four missed pilots drop lock", mb_lock, 0);
    chk(block_lock == 1, "R2 block lock kept over pilot loss", block_lock, 1);

    repeat (10) push_msg(0, 0, 0);
    send_all(0, 0);
    chk(mb_lock == 1, "R6 multiblock relock", mb_lock, 1);

    repeat (12) push_msg(0, 0, 0);
    send_all(20, 50);
    chk(stalls > 0, "R9 back-pressure exercised", stalls, 1);

    push_msg(0, 0, 32);
    push_msg(0, 0, 8);
    push_msg(0, 0, 0);
    send_all(0, 0);
    chk(block_lock == 0, "R3 error burst drops lock", block_lock, 0);
    chk(mb_lock == 0, "R10 multiblock lock cleared", mb_lock, 0);

    repeat (24) push_msg(0, 0, 0);
    send_all(5, 10);
    chk(block_lock == 1, "R2 block relock after slip search", block_lock, 1);
    chk(mb_lock == 1, "R6 multiblock relock after loss", mb_lock, 1);

    finish_run();
  end

endmodule